// File: doc/BRIEF.md
# Wallace Tree Unsigned Multiplier

This block multiplies two unsigned N-bit operands in a single combinational pass and returns the full 2N-bit product. The operand width N may be 4, 6 or 8. Each multiplier bit uses a two-way select to choose between the multiplicand and zero, and the result is moved up to that bit's weight. A tree of three-input carry-save stages then folds the partial products down to one sum word and one carry word. A single carry-propagate adder turns those two words into the product.

Every partial product, and the sum and carry words of every carry-save stage, is brought out on a flat observation port. A test harness or a debug view can therefore look at each node of the tree directly. All internal words are 2N bits wide and zero-extended, so no stage can lose a carry. Each carry word is presented already moved to its own weight: the carry produced from bit j sits at bit j+1.

Top module: `wallace_mult`

## Requirements
- R1: `product_o` equals the unsigned product of `mcand_i` and `mplier_i`, exactly and to 2N bits, for N = 4, 6 and 8.
- R2: Partial product i occupies bits [i*2N +: 2N] of `pp_obs_o`. It equals the multiplicand moved left by i bits when multiplier bit i is 1, and it is zero otherwise. Its upper bits are zero-extended.
- R3: The sum word of each carry-save stage is the bitwise XOR of that stage's three input words.
- R4: Bit j+1 of each stage's carry word is the majority of bit j of the three inputs. Bit 0 of the carry word is always zero. No carry moves along a stage.
- R5: For each stage, the sum word plus the carry word equals the sum of the stage's three inputs, modulo 2^(2N).
- R6: Stages are built level by level. At each level, the current list of words is cut into consecutive groups of three from the front, and each group forms a new stage. Any words left over pass unchanged to the next level. The list for the next level holds each new stage's sum and then its carry, in stage order, followed by the leftover words. Stage numbers follow creation order, and there are exactly N-2 stages. Stage k's sum and carry occupy bits [k*2N +: 2N] of `csa_sum_obs_o` and `csa_carry_obs_o`. For N = 6 the stages are:
  - stage 0 takes (pp0, pp1, pp2);
  - stage 1 takes (pp3, pp4, pp5);
  - stage 2 takes (s0, c0, s1);
  - stage 3 takes (s2, c2, c1).
  
  For N = 4 the stages are:
  - stage 0 takes (pp0, pp1, pp2);
  - stage 1 takes (s0, c0, pp3).
- R7: `product_o` equals the sum word plus the carry word of the last stage, added with full carry propagation.
- R8: With N = 6, operands 011010 and 110101 (26 and 53) give 10101100010 (1378).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_i | input | N | Multiplicand, unsigned |
| mplier_i | input | N | Multiplier, unsigned; bit i selects partial product i |
| product_o | output | 2N | Full unsigned product |
| pp_obs_o | output | N*2N | All partial products, word i at [i*2N +: 2N] |
| csa_sum_obs_o | output | (N-2)*2N | Sum word of each carry-save stage |
| csa_carry_obs_o | output | (N-2)*2N | Weight-aligned carry word of each carry-save stage |

## Verification
The bench targets operands that stress the tree:
- an all-ones multiplier with an all-ones multiplicand, where every full adder produces a carry;
- single-bit multipliers, where only one partial product is live;
- zero operands.

A tree that left out the one-bit move of a carry word, or that dropped the top carry because a word was too narrow, would give wrong high product bits on exactly these patterns. The bench also compares each stage's sum and carry words against a model of the fixed grouping. Swapping inputs between stages, or passing the wrong leftover word down a level, therefore shows up at the node where it happens even when the final product is still correct. N = 4 and N = 6 are swept over all operand pairs, and N = 8 over random pairs.

// File: rtl/wt_pkg.sv
// Package: shared elaboration-time helpers for the carry-save tree.
// Assumes operand widths small enough that the live word list fits in MAXV.
package wt_pkg;
    localparam int MAXV = 32;

    // Returns the node index feeding slot `slot` of stage `stage`, or,
    // when stage < 0, the index of final word `slot` (0 = sum, 1 = carry).
    // Nodes 0..n-1 are partial products; stage k makes nodes n+2k and n+2k+1.
    function automatic int wt_node(input int n, input int stage, input int slot);
        int cur [MAXV];
        int nxt [MAXV];
        int ncur;
        int nnxt;
        int nid;
        int cnt;
        int p;
        int res;
        for (int i = 0; i < MAXV; i++) begin
            cur[i] = 0;
            nxt[i] = 0;
        end
        for (int i = 0; i < n; i++) cur[i] = i;
        ncur = n;
        nid  = n;
        cnt  = 0;
        res  = 0;
        while (ncur > 2) begin
            nnxt = 0;
            p    = 0;
            while (ncur - p >= 3) begin
                if (cnt == stage) res = cur[p + slot];
                nxt[nnxt]     = nid;
                nxt[nnxt + 1] = nid + 1;
                nnxt = nnxt + 2;
                nid  = nid + 2;
                cnt  = cnt + 1;
                p    = p + 3;
            end
            while (p < ncur) begin
                nxt[nnxt] = cur[p];
                nnxt = nnxt + 1;
                p    = p + 1;
            end
            for (int i = 0; i < MAXV; i++) cur[i] = nxt[i];
            ncur = nnxt;
        end
        if (stage < 0) res = cur[slot];
        return res;
    endfunction
endpackage

// File: rtl/wt_ppgen.sv
// Partial-product generator: one 2:1 select per multiplier bit, chooses the
// multiplicand or zero, places it at weight i in a W-bit word.
// Assumes W >= 2*N so no partial product bit is lost.
module wt_ppgen #(
    parameter int N = 6,
    parameter int W = 2 * N
) (
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [N*W-1:0] pp_o
);
    // Select and align every partial product, then check each one.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            pp_o[i*W +: W] = b_i[i] ? (W'(a_i) << i) : '0;
        end
        if (!$isunknown({a_i, b_i})) begin
            for (int i = 0; i < N; i++) begin
                // R2
                pp_ones_chk: assert ($countones(pp_o[i*W +: W]) == (b_i[i] ? $countones(a_i) : 0))
                    else $error("partial product %0d has wrong population", i);
                // R2
                pp_align_chk: assert ((pp_o[i*W +: W] & ((W'(1) << i) - W'(1))) == '0)
                    else $error("partial product %0d has bits below its weight", i);
            end
        end
    end
endmodule

// File: rtl/wt_csa.sv
// Carry-save stage: a row of independent full adders over three W-bit words.
// The carry word is returned weight-aligned (carry of bit j at bit j+1);
// the carry out of bit W-1 is dropped, which is safe when W = 2N.
module wt_csa #(
    parameter int W = 12
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);
    // Bitwise full adders with no carry moving between positions.
    always_comb begin
        c_o = '0;
        for (int i = 0; i < W; i++) begin
            s_o[i] = x_i[i] ^ y_i[i] ^ z_i[i];
            if (i < W - 1) begin
                c_o[i+1] = (x_i[i] & y_i[i]) | (x_i[i] & z_i[i]) | (y_i[i] & z_i[i]);
            end
        end
        if (!$isunknown({x_i, y_i, z_i})) begin
            // R5
            csa_conserve_chk: assert ((s_o + c_o) == (x_i + y_i + z_i))
                else $error("carry-save stage does not conserve its total");
            // R4
            csa_carry_lsb_chk: assert (c_o[0] == 1'b0)
                else $error("carry word bit 0 is set");
        end
    end
endmodule

// File: rtl/wt_cpa.sv
// Carry-propagate adder: ripple sum of the final sum and carry words.
// Assumes the true total fits in W bits.
module wt_cpa #(
    parameter int W = 12
) (
    input  logic [W-1:0] s_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] p_o
);
    logic cy;

    // Ripple the carry from bit 0 upward, then check the total.
    always_comb begin
        cy = 1'b0;
        for (int i = 0; i < W; i++) begin
            p_o[i] = s_i[i] ^ c_i[i] ^ cy;
            cy     = (s_i[i] & c_i[i]) | (s_i[i] & cy) | (c_i[i] & cy);
        end
        if (!$isunknown({s_i, c_i})) begin
            // R7
            cpa_total_chk: assert (p_o == (s_i + c_i))
                else $error("carry-propagate adder total mismatch");
        end
    end
endmodule

// File: rtl/wallace_mult.sv
// Top: combinational unsigned N x N multiplier built as a carry-save tree.
// Assumes N is 4, 6 or 8. All tree nodes are W = 2N bits and exposed.
module wallace_mult #(
    parameter int N = 6
) (
    input  logic [N-1:0]               mcand_i,
    input  logic [N-1:0]               mplier_i,
    output logic [2*N-1:0]             product_o,
    output logic [N*2*N-1:0]           pp_obs_o,
    output logic [(N-2)*2*N-1:0]       csa_sum_obs_o,
    output logic [(N-2)*2*N-1:0]       csa_carry_obs_o
);
    localparam int W     = 2 * N;
    localparam int NST   = N - 2;
    localparam int NNODE = N + 2 * NST;
    localparam int FIN_S = wt_pkg::wt_node(N, -1, 0);
    localparam int FIN_C = wt_pkg::wt_node(N, -1, 1);

    logic [W-1:0] node [NNODE];

    wt_ppgen #(.N(N), .W(W)) u_ppgen (
        .a_i  (mcand_i),
        .b_i  (mplier_i),
        .pp_o (pp_obs_o)
    );

    // Partial products become the first N nodes of the tree.
    for (genvar i = 0; i < N; i++) begin : g_pp
        assign node[i] = pp_obs_o[i*W +: W];
    end

    // One carry-save stage per step of the fixed grouping schedule.
    for (genvar k = 0; k < NST; k++) begin : g_stage
        localparam int SX = wt_pkg::wt_node(N, k, 0);
        localparam int SY = wt_pkg::wt_node(N, k, 1);
        localparam int SZ = wt_pkg::wt_node(N, k, 2);
        wt_csa #(.W(W)) u_csa (
            .x_i (node[SX]),
            .y_i (node[SY]),
            .z_i (node[SZ]),
            .s_o (node[N + 2*k]),
            .c_o (node[N + 2*k + 1])
        );
        assign csa_sum_obs_o[k*W +: W]   = node[N + 2*k];
        assign csa_carry_obs_o[k*W +: W] = node[N + 2*k + 1];
    end

    wt_cpa #(.W(W)) u_cpa (
        .s_i (node[FIN_S]),
        .c_i (node[FIN_C]),
        .p_o (product_o)
    );
endmodule

// File: tb/wallace_mult_bench.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops and
// compares at the falling edge. Instances for N = 6 (main), 4 and 8.
module wallace_mult_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [5:0]  a6 = '0, b6 = '0;
    logic [11:0] p6;
    logic [71:0] pp6;
    logic [47:0] s6, c6;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  p4;
    logic [31:0] pp4;
    logic [15:0] s4, c4;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [15:0] p8;
    logic [127:0] pp8;
    logic [95:0] s8, c8;

    wallace_mult #(.N(6)) u_wallace_mult (.mcand_i(a6), .mplier_i(b6), .product_o(p6),
        .pp_obs_o(pp6), .csa_sum_obs_o(s6), .csa_carry_obs_o(c6));
    wallace_mult #(.N(4)) u_wallace_mult_4 (.mcand_i(a4), .mplier_i(b4), .product_o(p4),
        .pp_obs_o(pp4), .csa_sum_obs_o(s4), .csa_carry_obs_o(c4));
    wallace_mult #(.N(8)) u_wallace_mult_8 (.mcand_i(a8), .mplier_i(b8), .product_o(p8),
        .pp_obs_o(pp8), .csa_sum_obs_o(s8), .csa_carry_obs_o(c8));

    typedef struct {
        int         w;
        logic [7:0] a;
        logic [7:0] b;
    } item_t;
    item_t sbq[$];
    int checks = 0;
    int errors = 0;

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fa_s(logic [15:0] x, y, z);
        return x ^ y ^ z;
    endfunction
    function automatic logic [15:0] fa_c(logic [15:0] x, y, z, logic [15:0] m);
        return (((x & y) | (x & z) | (y & z)) << 1) & m;
    endfunction

    task automatic drive(int w, logic [7:0] x, logic [7:0] y);
        item_t it;
        @(posedge clk);
        case (w)
            4: begin a4 <= x[3:0]; b4 <= y[3:0]; end
            6: begin a6 <= x[5:0]; b6 <= y[5:0]; end
            default: begin a8 <= x; b8 <= y; end
        endcase
        it.w = w; it.a = x; it.b = y;
        sbq.push_back(it);
    endtask

    // Monitor: pop one expected item per cycle and compare every node.
    always @(negedge clk) begin
        if (rst_n && sbq.size() > 0) begin
            item_t it;
            logic [15:0] pp [8];
            logic [15:0] es [6];
            logic [15:0] ec [6];
            logic [15:0] m;
            it = sbq.pop_front();
            if (it.w == 6) begin
                m = 16'h0fff;
                for (int i = 0; i < 6; i++) pp[i] = it.b[i] ? (16'(it.a) << i) : 16'h0;
                es[0] = fa_s(pp[0], pp[1], pp[2]); ec[0] = fa_c(pp[0], pp[1], pp[2], m);
                es[1] = fa_s(pp[3], pp[4], pp[5]); ec[1] = fa_c(pp[3], pp[4], pp[5], m);
                es[2] = fa_s(es[0], ec[0], es[1]); ec[2] = fa_c(es[0], ec[0], es[1], m);
                es[3] = fa_s(es[2], ec[2], ec[1]); ec[3] = fa_c(es[2], ec[2], ec[1], m);
                chk("R1 N=6 product", 16'(p6), 16'(it.a) * 16'(it.b));
                for (int i = 0; i < 6; i++) chk("R2 N=6 partial product", 16'(pp6[i*12 +: 12]), pp[i]);
                for (int k = 0; k < 2; k++) begin
                    chk("R3 N=6 top stage sum", 16'(s6[k*12 +: 12]), es[k]);
                    chk("R4 N=6 top stage carry", 16'(c6[k*12 +: 12]), ec[k]);
                end
                for (int k = 2; k < 4; k++) begin
                    chk("R6 N=6 lower stage sum", 16'(s6[k*12 +: 12]), es[k]);
                    chk("R6 N=6 lower stage carry", 16'(c6[k*12 +: 12]), ec[k]);
                end
                chk("R5 N=6 stage 3 conservation", (16'(s6[36 +: 12]) + 16'(c6[36 +: 12])) & m,
                    (es[2] + ec[2] + ec[1]) & m);
                chk("R7 N=6 final adder", 16'(p6), 16'(s6[36 +: 12]) + 16'(c6[36 +: 12]));
                if (it.a == 8'd26 && it.b == 8'd53) chk("R8 worked example", 16'(p6), 16'b10101100010);
            end else if (it.w == 4) begin
                m = 16'h00ff;
                for (int i = 0; i < 4; i++) pp[i] = it.b[i] ? (16'(it.a) << i) : 16'h0;
                es[0] = fa_s(pp[0], pp[1], pp[2]); ec[0] = fa_c(pp[0], pp[1], pp[2], m);
                es[1] = fa_s(es[0], ec[0], pp[3]); ec[1] = fa_c(es[0], ec[0], pp[3], m);
                chk("R1 N=4 product", 16'(p4), 16'(it.a) * 16'(it.b));
                chk("R6 N=4 stage 1 sum", 16'(s4[8 +: 8]), es[1]);
                chk("R6 N=4 stage 1 carry", 16'(c4[8 +: 8]), ec[1]);
            end else begin
                chk("R1 N=8 product", p8, 16'(it.a) * 16'(it.b));
                chk("R7 N=8 final adder", p8, s8[80 +: 16] + c8[80 +: 16]);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        chk("R1 reset state product zero", 16'(p6), 16'h0);
        drive(6, 8'd26, 8'd53);
        drive(6, 8'd63, 8'd63);
        drive(8, 8'hff, 8'hff);
        drive(4, 8'hf, 8'hf);
        for (int i = 0; i < 6; i++) drive(6, 8'd63, 8'(1 << i));
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++) drive(4, 8'(x), 8'(y));
        for (int x = 0; x < 64; x++)
            for (int y = 0; y < 64; y++) drive(6, 8'(x), 8'(y));
        for (int i = 0; i < 2000; i++) drive(8, 8'($urandom), 8'($urandom));
        while (sbq.size() > 0) @(posedge clk);
        @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule